// File: doc/BRIEF.md
# UART Channel with Mode Control Register

This block is one asynchronous serial channel governed by an 8-bit mode register. The register sits on a simple byte-wide bus with separate write, single-bit write and read strobes. Software uses it to turn the channel on, enable each direction, and pick the character format: parity kind, 7- or 8-bit characters, one or two stop bits. It also chooses how receive errors are signalled. The bus also reaches a transmit data port, a receive buffer, a receive status register and a transmit status register.

A 16x oversampling tick comes from outside the block and paces both directions. The transmitter sends a start bit, the data LSB first, an optional parity bit and the stop bits. The receiver samples each bit at its midpoint and records parity, framing and overrun errors.

Enabling follows a fixed order. Turning the channel off puts it back in its initial state. The transmit unit only re-initialises after a minimum disabled interval. A receiver enabled on a low line takes that low level as a start bit.

Top module: `uart_mc_top`

## Requirements
- R1: After reset the mode register (bus address 0) reads 0x01. Its bits are: [7] channel on, [6] transmit enable, [5] receive enable, [4:3] parity kind, [2] character length (0 = 7 bits, 1 = 8 bits), [1] stop length (0 = one stop bit, 1 = two), [0] error-signal mode.
- R2: A single-bit write (bus_bitwr at address 0) stores bus_wdata[3] into bit bus_wdata[2:0] of the mode register and leaves the other bits unchanged.
- R3: While the channel-on bit is 0, the receive buffer (address 1), the receive status (address 2) and the transmit status (address 3) all read 0, and any contents they held are cleared at once.
- R4: When a write turns the channel-on bit from 1 to 0, by byte or by single bit, the mode register returns to 0x01 whatever value was written.
- R5: txd is high in every cycle where transmit enable is 0, whether or not the channel is on.
- R6: Holding transmit enable at 0 for two or more clocks aborts a frame in progress, so transmit status bit 0 (busy) reads 0. A one-clock low pulse leaves the frame running and busy still reads 1.
- R7: A byte write to address 1 while transmit is enabled and idle starts a frame. The frame is a start bit (0), the data LSB first (7 or 8 bits), a parity bit, then one or two stop bits (1). Each bit lasts 16 ticks. Busy reads 1 until the last stop bit ends. Writes while busy or while transmit is disabled are ignored.
- R8: The receiver samples each bit at its midpoint. On the stop-bit sample it puts the character in the receive buffer (zero-extended for 7 bits) and sets status bit 3 (ready). Reading address 1 clears ready.
- R9: Parity kinds are 00 none, 01 zero, 10 odd, 11 even. A wrong parity bit sets status bit 0, and a low stop bit sets status bit 1 (framing).
- R10: A character that completes while ready is still set raises status bit 2 (overrun). The newer character replaces the buffer contents.
- R11: If receive enable becomes 1 while rxd is low, that low level is treated as a start bit and the character that follows is received.
- R12: Each received character gives a one-cycle interrupt pulse. With the error-signal mode bit 0 this is always on rx_irq. With it 1, a character with a parity or framing error pulses err_irq instead. The two outputs are never high together.
- R13: Any write to address 2 clears the three error flags in the status register and leaves ready unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| bus_addr | input | 2 | Register address: 0 mode, 1 data, 2 status, 3 transmit status |
| bus_wdata | input | 8 | Write data; for single-bit writes [2:0] is the bit index and [3] the value |
| bus_wr | input | 1 | Byte write strobe |
| bus_bitwr | input | 1 | Single-bit write strobe (mode register only) |
| bus_rd | input | 1 | Read strobe (a read of address 1 clears ready) |
| bus_rdata | output | 8 | Read data for bus_addr |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_irq | output | 1 | Receive interrupt pulse |
| err_irq | output | 1 | Receive-error interrupt pulse |

## Verification
Some properties are checked on every cycle. The line stays high whenever transmit is off. A disabled channel reads back zeros on every data address. Each fall of the channel-on bit lands the mode register on 0x01. Two disabled clocks always leave the transmitter idle. Overrun never appears without ready, and the two interrupt pulses are never high together. Only the bench scenarios can show the frame format across all parity, length and stop settings, mid-bit sampling through loopback, the error and overrun flags, and reception starting at once on a line already low.

// File: rtl/uart_mc_pkg.sv
package uart_mc_pkg;

   typedef enum logic [1:0] {
      PAR_NONE = 2'b00,
      PAR_ZERO = 2'b01,
      PAR_ODD  = 2'b10,
      PAR_EVEN = 2'b11
   } par_e;

   typedef struct packed {
      logic chan_on;
      logic tx_on;
      logic rx_on;
      par_e par;
      logic len8;
      logic stop2;
      logic err_mode;
   } mode_t;

   localparam logic [7:0] MODE_INIT = 8'h01;

   localparam logic [1:0] ADDR_MODE = 2'd0;
   localparam logic [1:0] ADDR_DATA = 2'd1;
   localparam logic [1:0] ADDR_STAT = 2'd2;
   localparam logic [1:0] ADDR_TXST = 2'd3;

   localparam int ST_PERR = 0;
   localparam int ST_FERR = 1;
   localparam int ST_OVR  = 2;
   localparam int ST_RDY  = 3;

endpackage

// File: rtl/uart_mc_sync.sv
module uart_mc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= 1'b1;
            else        chain_q <= din;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], din};
         end
      end
   endgenerate

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/uart_mc_tx.sv
module uart_mc_tx
   import uart_mc_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int OVS      = 16,
   parameter int INIT_CYC = 2
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              tick,
   input  logic              tx_on,
   input  logic              start,
   input  logic [DATA_W-1:0] data,
   input  par_e              par,
   input  logic              len8,
   input  logic              stop2,
   output logic              txd,
   output logic              busy
);
   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(OVS);
   localparam int NB_W    = $clog2(FRAME_W + 1);
   localparam int LC_W    = $clog2(INIT_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
   localparam logic [LC_W-1:0]  LC_FULL  = LC_W'(INIT_CYC);

   logic [LC_W-1:0]    low_q;
   logic               unit_clr;
   logic [FRAME_W-1:0] frame, sh_q;
   logic [NB_W-1:0]    nbits, left_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               busy_q;
   logic [DATA_W-1:0]  dmask;
   logic               pbit;

   // count consecutive disabled clocks; the unit clears on the last one
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)           low_q <= '0;
      else if (tx_on)        low_q <= '0;
      else if (low_q < LC_FULL) low_q <= low_q + 1'b1;
   end
   assign unit_clr = !tx_on && (low_q >= LC_W'(INIT_CYC - 1));

   always_comb begin
      int pos;
      dmask = data;
      if (!len8) dmask[DATA_W-1] = 1'b0;
      case (par)
         PAR_ZERO: pbit = 1'b0;
         PAR_ODD:  pbit = ~(^dmask);
         PAR_EVEN: pbit = ^dmask;
         default:  pbit = 1'b0;
      endcase
      frame    = '1;
      frame[0] = 1'b0;
      pos      = 1;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < DATA_W - 1 || len8) begin
            frame[pos] = dmask[i];
            pos        = pos + 1;
         end
      end
      if (par != PAR_NONE) begin
         frame[pos] = pbit;
         pos        = pos + 1;
      end
      nbits = NB_W'(pos + 1 + int'(stop2));
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         busy_q <= 1'b0;
         sh_q   <= '1;
         left_q <= '0;
         cnt_q  <= '0;
      end else if (unit_clr) begin
         busy_q <= 1'b0;
         sh_q   <= '1;
         left_q <= '0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q <= 1'b1;
            sh_q   <= frame;
            left_q <= nbits;
            cnt_q  <= '0;
         end
      end else if (tick) begin
         if (cnt_q == CNT_LAST) begin
            cnt_q  <= '0;
            sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
            left_q <= left_q - 1'b1;
            if (left_q == NB_W'(1)) busy_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign txd  = (tx_on && busy_q) ? sh_q[0] : 1'b1;
   assign busy = busy_q;

   // R6: once the disabled run reaches the init length the unit is idle
   assert_tx_init_R6: assert property (@(posedge clk) disable iff (!arst_n)
      (low_q >= LC_FULL) |-> !busy_q);
endmodule

// File: rtl/uart_mc_rx.sv
module uart_mc_rx
   import uart_mc_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              tick,
   input  logic              rx_on,
   input  logic              rxs,
   input  par_e              par,
   input  logic              len8,
   output logic              done,
   output logic [DATA_W-1:0] data,
   output logic              perr,
   output logic              ferr
);
   localparam int CNT_W = $clog2(OVS);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
   localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS / 2 - 1);

   typedef enum logic [2:0] {
      RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
   } rx_state_e;

   rx_state_e         st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q, idx_last;
   logic [DATA_W-1:0] sh_q;
   logic              pbit_q;
   logic              samp;
   logic              perr_calc;

   assign idx_last = len8 ? IDX_W'(DATA_W - 1) : IDX_W'(DATA_W - 2);
   assign samp     = tick && (cnt_q == CNT_LAST);

   always_comb begin
      case (par)
         PAR_ZERO: perr_calc = pbit_q;
         PAR_ODD:  perr_calc = ~(^sh_q ^ pbit_q);
         PAR_EVEN: perr_calc = ^sh_q ^ pbit_q;
         default:  perr_calc = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         st_q   <= RX_IDLE;
         cnt_q  <= '0;
         idx_q  <= '0;
         sh_q   <= '0;
         pbit_q <= 1'b0;
         done   <= 1'b0;
         data   <= '0;
         perr   <= 1'b0;
         ferr   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick && st_q != RX_IDLE && st_q != RX_HOLD)
            cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
         if (!rx_on) begin
            st_q <= RX_IDLE;
         end else begin
            case (st_q)
               RX_IDLE: if (!rxs) begin
                  st_q  <= RX_START;
                  cnt_q <= '0;
               end
               RX_START: if (tick && cnt_q == CNT_HALF) begin
                  cnt_q <= '0;
                  if (!rxs) begin
                     st_q  <= RX_DATA;
                     idx_q <= '0;
                     sh_q  <= '0;
                  end else begin
                     st_q <= RX_IDLE;
                  end
               end
               RX_DATA: if (samp) begin
                  sh_q[idx_q] <= rxs;
                  if (idx_q == idx_last)
                     st_q <= (par == PAR_NONE) ? RX_STOP : RX_PAR;
                  else
                     idx_q <= idx_q + 1'b1;
               end
               RX_PAR: if (samp) begin
                  pbit_q <= rxs;
                  st_q   <= RX_STOP;
               end
               RX_STOP: if (samp) begin
                  done <= 1'b1;
                  data <= sh_q;
                  ferr <= !rxs;
                  perr <= perr_calc;
                  st_q <= rxs ? RX_IDLE : RX_HOLD;
               end
               RX_HOLD: if (rxs) st_q <= RX_IDLE;
               default: st_q <= RX_IDLE;
            endcase
         end
      end
   end

   // R8: a character only completes while the receiver was enabled
   assert_done_enabled_R8: assert property (@(posedge clk) disable iff (!arst_n)
      done |-> $past(rx_on));
endmodule

// File: rtl/uart_mc_regs.sv
module uart_mc_regs
   import uart_mc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] bus_addr,
   input  logic [7:0] bus_wdata,
   input  logic       bus_wr,
   input  logic       bus_bitwr,
   input  logic       bus_rd,
   input  logic       rx_done,
   input  logic [7:0] rx_data,
   input  logic       rx_perr,
   input  logic       rx_ferr,
   input  logic       tx_busy,
   output mode_t      mode,
   output logic       chan_rst_n,
   output logic       tx_start,
   output logic [7:0] bus_rdata,
   output logic       rx_irq,
   output logic       err_irq
);
   mode_t      mode_q;
   logic [7:0] mode_n;
   logic [7:0] rxbuf_q;
   logic [3:0] stat_q;
   logic       rd_data, wr_stat;

   always_comb begin
      mode_n = mode_q;
      if (bus_wr && bus_addr == ADDR_MODE)
         mode_n = bus_wdata;
      else if (bus_bitwr && bus_addr == ADDR_MODE)
         mode_n[bus_wdata[2:0]] = bus_wdata[3];
      if (mode_q.chan_on && !mode_n[7])
         mode_n = MODE_INIT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= mode_t'(MODE_INIT);
      else        mode_q <= mode_t'(mode_n);
   end

   assign mode       = mode_q;
   assign chan_rst_n = rst_n & mode_q.chan_on;
   assign rd_data    = bus_rd && bus_addr == ADDR_DATA;
   assign wr_stat    = bus_wr && bus_addr == ADDR_STAT;
   assign tx_start   = bus_wr && bus_addr == ADDR_DATA && mode_q.tx_on && !tx_busy;

   always_ff @(posedge clk or negedge chan_rst_n) begin
      if (!chan_rst_n) begin
         stat_q  <= '0;
         rxbuf_q <= '0;
         rx_irq  <= 1'b0;
         err_irq <= 1'b0;
      end else begin
         logic [2:0] errs;
         errs = wr_stat ? 3'b000 : stat_q[ST_OVR:ST_PERR];
         rx_irq  <= rx_done && (!mode_q.err_mode || !(rx_perr || rx_ferr));
         err_irq <= rx_done && mode_q.err_mode && (rx_perr || rx_ferr);
         if (rx_done) begin
            rxbuf_q         <= rx_data;
            stat_q[ST_RDY]  <= 1'b1;
            stat_q[ST_PERR] <= errs[ST_PERR] | rx_perr;
            stat_q[ST_FERR] <= errs[ST_FERR] | rx_ferr;
            stat_q[ST_OVR]  <= errs[ST_OVR] | (stat_q[ST_RDY] && !rd_data);
         end else begin
            stat_q[ST_OVR:ST_PERR] <= errs;
            if (rd_data) stat_q[ST_RDY] <= 1'b0;
         end
      end
   end

   always_comb begin
      case (bus_addr)
         ADDR_MODE: bus_rdata = mode_q;
         ADDR_DATA: bus_rdata = rxbuf_q;
         ADDR_STAT: bus_rdata = {4'b0, stat_q};
         default:   bus_rdata = {7'b0, tx_busy};
      endcase
   end

   // R4: the cycle after the channel bit drops, the register holds its initial value
   assert_mode_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mode_q.chan_on) |-> (mode_q == mode_t'(MODE_INIT)));
   // R10: overrun only ever rises together with a held character
   assert_ovr_needs_rdy_R10: assert property (@(posedge clk) disable iff (!chan_rst_n)
      $rose(stat_q[ST_OVR]) |-> stat_q[ST_RDY]);
   // R12: the two interrupt pulses exclude each other
   assert_irq_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rx_irq, err_irq}));
endmodule

// File: rtl/uart_mc_top.sv
module uart_mc_top
   import uart_mc_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int INIT_CYC    = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic [1:0] bus_addr,
   input  logic [7:0] bus_wdata,
   input  logic       bus_wr,
   input  logic       bus_bitwr,
   input  logic       bus_rd,
   output logic [7:0] bus_rdata,
   output logic       txd,
   input  logic       rxd,
   output logic       rx_irq,
   output logic       err_irq
);
   generate
      if (DATA_W < 5 || DATA_W > 8) begin : g_bad_w
         $error("uart_mc_top: DATA_W must lie in 5..8");
      end
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("uart_mc_top: OVS must be even and at least 4");
      end
      if (SYNC_STAGES < 1 || INIT_CYC < 1) begin : g_bad_misc
         $error("uart_mc_top: SYNC_STAGES and INIT_CYC must be at least 1");
      end
   endgenerate

   mode_t             mode;
   logic              chan_rst_n, tx_start, tx_busy;
   logic              rxs, rx_done, rx_perr, rx_ferr;
   logic [DATA_W-1:0] rx_data;

   uart_mc_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(rxd), .dout(rxs)
   );

   uart_mc_regs u_regs (
      .clk(clk), .rst_n(rst_n),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
      .bus_bitwr(bus_bitwr), .bus_rd(bus_rd),
      .rx_done(rx_done), .rx_data(8'(rx_data)), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
      .tx_busy(tx_busy), .mode(mode), .chan_rst_n(chan_rst_n), .tx_start(tx_start),
      .bus_rdata(bus_rdata), .rx_irq(rx_irq), .err_irq(err_irq)
   );

   uart_mc_tx #(.DATA_W(DATA_W), .OVS(OVS), .INIT_CYC(INIT_CYC)) u_tx (
      .clk(clk), .arst_n(chan_rst_n), .tick(baud_tick), .tx_on(mode.tx_on),
      .start(tx_start), .data(bus_wdata[DATA_W-1:0]), .par(mode.par),
      .len8(mode.len8), .stop2(mode.stop2), .txd(txd), .busy(tx_busy)
   );

   uart_mc_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
      .clk(clk), .arst_n(chan_rst_n), .tick(baud_tick), .rx_on(mode.rx_on),
      .rxs(rxs), .par(mode.par), .len8(mode.len8),
      .done(rx_done), .data(rx_data), .perr(rx_perr), .ferr(rx_ferr)
   );

   // R5: line idles high whenever transmit is switched off
   assert_txd_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mode.tx_on |-> txd);
   // R3: a disabled channel shows zeros on every data address
   assert_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode.chan_on && bus_addr != ADDR_MODE) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/uart_mc_top_bench.sv
module uart_mc_top_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic       wr = 1'b0, bitwr = 1'b0, rd = 1'b0;
   logic [7:0] rdata;
   logic       txd, rxd, rx_irq, err_irq;
   logic       loop_en = 1'b1, drv_rxd = 1'b1;
   int         n_chk = 0, n_fail = 0, n_rxi = 0, n_erri = 0, tdiv = 0;

   assign rxd = loop_en ? txd : drv_rxd;

   uart_mc_top u_uart_mc_top (
      .clk(clk), .rst_n(rst_n), .baud_tick(tick), .bus_addr(addr), .bus_wdata(wdata),
      .bus_wr(wr), .bus_bitwr(bitwr), .bus_rd(rd), .bus_rdata(rdata),
      .txd(txd), .rxd(rxd), .rx_irq(rx_irq), .err_irq(err_irq)
   );

   always #2 clk = ~clk;

   always @(negedge clk) begin
      tick = (tdiv == 3);
      tdiv = (tdiv + 1) % 4;
   end

   always @(posedge clk) begin
      if (rx_irq)  n_rxi++;
      if (err_irq) n_erri++;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_bit(input int idx, input logic v);
      addr = 2'd0; wdata = {4'b0, v, 3'(idx)}; bitwr = 1'b1;
      @(negedge clk);
      bitwr = 1'b0;
   endtask

   task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
      addr = a; rd = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   function automatic logic [7:0] mk_mode(input logic ch, input logic tx, input logic rx,
         input logic [1:0] par, input logic len8, input logic stop2, input logic em);
      return {ch, tx, rx, par, len8, stop2, em};
   endfunction

   function automatic void mkframe(input logic [7:0] d, input logic len8, input logic [1:0] par,
         input logic stop2, output logic [15:0] f, output int n);
      logic [7:0] dm;
      logic p;
      int nd;
      nd = len8 ? 8 : 7;
      dm = len8 ? d : (d & 8'h7F);
      f = '1; f[0] = 1'b0; n = 1;
      for (int i = 0; i < nd; i++) begin f[n] = dm[i]; n++; end
      if (par != 2'd0) begin
         p = (par == 2'd1) ? 1'b0 : (par == 2'd2) ? ~(^dm) : ^dm;
         f[n] = p; n++;
      end
      n = n + 1 + int'(stop2);
   endfunction

   task automatic send_raw(input logic [15:0] f, input int n, input int first);
      for (int i = first; i < n; i++) begin drv_rxd = f[i]; cycles(64); end
      drv_rxd = 1'b1;
      cycles(64);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0]  v, d;
      logic [15:0] f;
      int          n, rx0, er0;
      void'($urandom(32'd20240611));
      cycles(4);
      rst_n = 1'b1;
      cycles(2);

      // reset state
      bus_read(2'd0, v); chk("R1 mode reset", v, 8'h01);
      bus_read(2'd2, v); chk("R3 status reset", v, 8'h00);
      bus_read(2'd1, v); chk("R3 rxbuf reset", v, 8'h00);
      bus_read(2'd3, v); chk("R3 txstat reset", v, 8'h00);
      chk("R5 txd idle", txd, 1'b1);

      // single-bit writes
      bus_bit(7, 1'b1);
      bus_read(2'd0, v); chk("R2 bit set", v, 8'h81);
      bus_bit(0, 1'b0);
      bus_read(2'd0, v); chk("R2 bit clear", v, 8'h80);

      // transmit disabled: data write ignored, line stays high
      bus_write(2'd1, 8'h00);
      cycles(40);
      chk("R5 txd high while disabled", txd, 1'b1);
      bus_read(2'd3, v); chk("R7 write ignored when disabled", v, 8'h00);

      // direct frame check: 8 bits, even parity, one stop
      bus_write(2'd0, mk_mode(1, 1, 1, 2'd3, 1, 0, 1));
      cycles(4);
      d = 8'hA6;
      mkframe(d, 1, 2'd3, 0, f, n);
      bus_write(2'd1, d);
      bus_read(2'd3, v); chk("R7 busy after start", v, 8'h01);
      bus_write(2'd1, 8'h3C);                 // ignored while busy
      cycles(28);
      for (int i = 0; i < n; i++) begin
         chk($sformatf("R7 txd bit %0d", i), txd, f[i]);
         cycles(64);
      end
      cycles(100);
      bus_read(2'd3, v); chk("R7 idle after frame", v, 8'h00);
      bus_read(2'd1, v); chk("R7 busy write ignored, R8 data", v, d);

      // loopback sweep over every format
      rx0 = n_rxi; er0 = n_erri;
      for (int par = 0; par < 4; par++)
         for (int ln = 0; ln < 2; ln++)
            for (int sb = 0; sb < 2; sb++)
               for (int k = 0; k < 2; k++) begin
                  bus_write(2'd0, mk_mode(1, 1, 1, 2'(par), 1'(ln), 1'(sb), 1));
                  cycles(4);
                  d = 8'($urandom);
                  mkframe(d, 1'(ln), 2'(par), 1'(sb), f, n);
                  bus_write(2'd1, d);
                  cycles(n * 64 + 120);
                  bus_read(2'd2, v);
                  chk($sformatf("R9 status p%0d l%0d s%0d", par, ln, sb), v, 8'h08);
                  bus_read(2'd1, v);
                  chk($sformatf("R8 loopback p%0d l%0d s%0d", par, ln, sb), v,
                      ln != 0 ? d : (d & 8'h7F));
                  bus_read(2'd2, v); chk("R8 ready cleared by read", v, 8'h00);
               end
      chk("R12 rx_irq per good char", n_rxi - rx0, 32);
      chk("R12 no err_irq on good chars", n_erri - er0, 0);

      // error detection with the bench driving the line
      loop_en = 1'b0;
      bus_write(2'd0, mk_mode(1, 1, 1, 2'd2, 1, 0, 1));
      cycles(4);
      rx0 = n_rxi; er0 = n_erri;
      mkframe(8'h5B, 1, 2'd2, 0, f, n);
      f[9] = ~f[9];
      send_raw(f, n, 0);
      bus_read(2'd2, v); chk("R9 parity error", v, 8'h09);
      chk("R12 err_irq in mode 1", n_erri - er0, 1);
      chk("R12 no rx_irq in mode 1", n_rxi - rx0, 0);
      bus_write(2'd2, 8'h00);
      bus_read(2'd2, v); chk("R13 clear keeps ready", v, 8'h08);
      bus_read(2'd1, v); chk("R9 data despite parity", v, 8'h5B);
      mkframe(8'h11, 1, 2'd2, 0, f, n);
      f[10] = 1'b0;
      send_raw(f, n, 0);
      bus_read(2'd2, v); chk("R9 framing error", v, 8'h0A);
      bus_read(2'd1, v);
      bus_write(2'd2, 8'h00);
      bus_read(2'd2, v); chk("R13 errors cleared", v, 8'h00);

      // error-signal mode 0 routes errors to rx_irq
      bus_write(2'd0, mk_mode(1, 1, 1, 2'd1, 0, 1, 0));
      cycles(4);
      rx0 = n_rxi; er0 = n_erri;
      mkframe(8'h2D, 0, 2'd1, 1, f, n);
      f[8] = 1'b1;
      send_raw(f, n, 0);
      chk("R12 rx_irq in mode 0", n_rxi - rx0, 1);
      chk("R12 no err_irq in mode 0", n_erri - er0, 0);
      bus_read(2'd2, v); chk("R9 zero parity violated", v, 8'h09);
      bus_read(2'd1, v);
      bus_write(2'd2, 8'h00);

      // overrun
      bus_write(2'd0, mk_mode(1, 1, 1, 2'd0, 1, 0, 1));
      cycles(4);
      mkframe(8'hC3, 1, 2'd0, 0, f, n); send_raw(f, n, 0);
      mkframe(8'h7E, 1, 2'd0, 0, f, n); send_raw(f, n, 0);
      bus_read(2'd2, v); chk("R10 overrun flag", v, 8'h0C);
      bus_read(2'd1, v); chk("R10 newer char kept", v, 8'h7E);
      bus_write(2'd2, 8'h00);

      // enabling reception on a low line
      bus_write(2'd0, mk_mode(1, 1, 0, 2'd0, 1, 0, 1));
      drv_rxd = 1'b0;
      cycles(100);
      bus_read(2'd2, v); chk("R11 nothing before enable", v, 8'h00);
      bus_write(2'd0, mk_mode(1, 1, 1, 2'd0, 1, 0, 1));
      cycles(63);
      mkframe(8'h96, 1, 2'd0, 0, f, n);
      send_raw(f, n, 1);
      bus_read(2'd2, v); chk("R11 char on enable", v, 8'h08);
      bus_read(2'd1, v); chk("R11 data", v, 8'h96);

      // transmit re-initialisation interval
      loop_en = 1'b1;
      bus_write(2'd0, mk_mode(1, 1, 0, 2'd0, 1, 0, 1));
      cycles(4);
      bus_write(2'd1, 8'h55);
      cycles(100);
      bus_bit(6, 1'b0);
      bus_bit(6, 1'b1);
      bus_read(2'd3, v); chk("R6 short pulse keeps frame", v, 8'h01);
      cycles(700);
      bus_write(2'd1, 8'h55);
      cycles(100);
      bus_bit(6, 1'b0);
      cycles(2);
      bus_bit(6, 1'b1);
      bus_read(2'd3, v); chk("R6 long pulse clears unit", v, 8'h00);
      chk("R6 line idle after clear", txd, 1'b1);

      // channel off clears everything
      bus_write(2'd0, mk_mode(1, 1, 1, 2'd0, 1, 0, 1));
      cycles(4);
      bus_write(2'd1, 8'h81);
      cycles(10 * 64 + 120);
      bus_read(2'd2, v); chk("R8 ready before off", v, 8'h08);
      bus_write(2'd0, 8'h65);
      bus_read(2'd0, v); chk("R4 mode back to init", v, 8'h01);
      bus_read(2'd2, v); chk("R3 status cleared", v, 8'h00);
      bus_read(2'd1, v); chk("R3 rxbuf cleared", v, 8'h00);
      bus_write(2'd0, mk_mode(1, 1, 1, 2'd3, 0, 1, 0));
      bus_bit(7, 1'b0);
      bus_read(2'd0, v); chk("R4 bit write off", v, 8'h01);
      chk("R5 txd high after off", txd, 1'b1);

      finish_run();
   end
endmodule